// File: doc/BRIEF.md
# Stack CPU Interrupt Entry Sequencer

This block sits beside the control unit of a zero-operand stack processor and decides when an external interrupt is taken. It watches one interrupt request line and treats it as edge-triggered. A new rising edge marks an interrupt as pending. Entry is held off while the core is chaining immediate-load opcodes, and it only starts on an instruction-boundary strobe, so the block never splits a partly executed opcode.

Once it accepts an interrupt, the block stands in for an interrupt pseudo-instruction, in two steps:
- It asks the core to push the captured program counter onto the data stack as the return address.
- It then asks the core to branch to a fixed low vector.

Each step waits for a done handshake from the core. When the branch completes, the block drives a one-cycle acknowledge back to the requester and clears the pending state. The block has no enable or mask bit of its own. Per-source enabling belongs to an external memory-mapped controller.

Top module: `irq_entry_seq`

## Requirements
- R1: A rising edge on `irq_req_i` marks an interrupt as pending. The edge is seen as `irq_req_i`=1 in a cycle after a cycle in which it was 0, and reset counts as a 0 sample. A level that is held without an edge creates no new pending interrupt.
- R2: One continuous assertion of `irq_req_i` is accepted at most once. After the acknowledge, a line that stays high causes no second entry.
- R3: An interrupt is accepted in a cycle where it is pending, `insn_bound_i`=1, `imm_cont_i`=0 and no entry is in progress. In the next cycle `push_req_o`=1, and `push_data_o` equals `pc_i` as sampled in the accepting cycle.
- R4: While `jump_req_o`=1, `jump_addr_o` equals `VEC_ADDR` (default 0x20).
- R5: `irq_ack_o` is high for exactly one cycle, the cycle after the one in which `jump_done_i`=1 is seen with `jump_req_o`=1. The pending interrupt is cleared at the same clock edge.
- R6: The push comes strictly before the branch. `push_req_o` stays high, with stable data, until `push_done_i`=1. `jump_req_o` rises only in the cycle after that, and it stays high until `jump_done_i`=1.
- R7: No interrupt is accepted while `imm_cont_i`=1. A pending interrupt waits, and it is accepted at the first boundary after the flag clears.
- R8: No interrupt is accepted in a cycle where `insn_bound_i`=0.
- R9: If `irq_req_i` falls after its rising edge but before the acknowledge, the interrupt is still serviced.
- R10: `irq_busy_o` is 1 from the cycle after acceptance through the acknowledge cycle, and 0 otherwise.
- R11: An active-low asynchronous reset clears the pending state, the previous-sample register and any entry in progress, so every output reads 0. If the line is still high after reset, that line counts as a new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Interrupt request line, edge-sensitive |
| imm_cont_i | input | 1 | Core is assembling chained immediates |
| insn_bound_i | input | 1 | One-cycle instruction-boundary strobe |
| pc_i | input | PC_W | Current program counter (return address) |
| push_req_o | output | 1 | Request to push the return PC onto the stack |
| push_data_o | output | PC_W | Return PC to push |
| push_done_i | input | 1 | Core has completed the push |
| jump_req_o | output | 1 | Request to redirect fetch |
| jump_addr_o | output | PC_W | Vector address |
| jump_done_i | input | 1 | Core has completed the redirect |
| irq_ack_o | output | 1 | One-cycle acknowledge to the requester |
| irq_busy_o | output | 1 | Entry sequence in progress |

## Verification
The bench builds the block with its defaults: PC_W=32 and VEC_ADDR=0x20. At these values the full 32-bit return address passes through to the push data, and the vector value can be checked against the literal 0x20. Directed scenarios stretch the core handshakes over several cycles. They also hold the immediate flag and withhold the boundary strobe, which exposes premature acceptance and any handshake step that is skipped. Line drops, held levels and a reset partway through entry probe the edge detector and the pending state.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_JUMP = 2'd2,
    ST_ACK  = 2'd3
  } entry_state_e;
endpackage

// File: rtl/irq_edge_pend.sv
module irq_edge_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_req_i,
  input  logic clr_i,
  output logic pend_o
);
  logic irq_q;
  logic pend_q;
  logic rise;

  assign rise = irq_req_i & ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      irq_q  <= irq_req_i;
      // new edge in the clear cycle survives
      pend_q <= (pend_q & ~clr_i) | rise;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int unsigned      PC_W     = 32,
  parameter logic [PC_W-1:0]  VEC_ADDR = PC_W'(32'h20)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pend_i,
  input  logic            imm_cont_i,
  input  logic            insn_bound_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            push_done_i,
  input  logic            jump_done_i,
  output logic            push_req_o,
  output logic [PC_W-1:0] push_data_o,
  output logic            jump_req_o,
  output logic [PC_W-1:0] jump_addr_o,
  output logic            ack_o,
  output logic            busy_o
);
  entry_state_e state_q, state_d;
  logic [PC_W-1:0] ret_pc_q;
  logic take;

  assign take = (state_q == ST_IDLE) & pend_i & insn_bound_i & ~imm_cont_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take)        state_d = ST_PUSH;
      ST_PUSH: if (push_done_i) state_d = ST_JUMP;
      ST_JUMP: if (jump_done_i) state_d = ST_ACK;
      ST_ACK:                   state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ret_pc_q <= '0;
    end else begin
      state_q <= state_d;
      if (take) ret_pc_q <= pc_i;
    end
  end

  assign push_req_o  = (state_q == ST_PUSH);
  assign push_data_o = push_req_o ? ret_pc_q : '0;
  assign jump_req_o  = (state_q == ST_JUMP);
  assign jump_addr_o = jump_req_o ? VEC_ADDR : '0;
  assign ack_o       = (state_q == ST_ACK);
  assign busy_o      = (state_q != ST_IDLE);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int unsigned      PC_W     = 32,
  parameter logic [PC_W-1:0]  VEC_ADDR = PC_W'(32'h20)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            irq_req_i,
  input  logic            imm_cont_i,
  input  logic            insn_bound_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            push_req_o,
  output logic [PC_W-1:0] push_data_o,
  input  logic            push_done_i,
  output logic            jump_req_o,
  output logic [PC_W-1:0] jump_addr_o,
  input  logic            jump_done_i,
  output logic            irq_ack_o,
  output logic            irq_busy_o
);
  logic pend;
  logic ack;

  irq_edge_pend u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_req_i (irq_req_i),
    .clr_i     (ack),
    .pend_o    (pend)
  );

  irq_entry_fsm #(
    .PC_W     (PC_W),
    .VEC_ADDR (VEC_ADDR)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pend_i       (pend),
    .imm_cont_i   (imm_cont_i),
    .insn_bound_i (insn_bound_i),
    .pc_i         (pc_i),
    .push_done_i  (push_done_i),
    .jump_done_i  (jump_done_i),
    .push_req_o   (push_req_o),
    .push_data_o  (push_data_o),
    .jump_req_o   (jump_req_o),
    .jump_addr_o  (jump_addr_o),
    .ack_o        (ack),
    .busy_o       (irq_busy_o)
  );

  assign irq_ack_o = ack;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            imm_cont_i,
  input logic            insn_bound_i,
  input logic [PC_W-1:0] pc_i,
  input logic            push_req_o,
  input logic [PC_W-1:0] push_data_o,
  input logic            push_done_i,
  input logic            jump_req_o,
  input logic            jump_done_i,
  input logic            irq_ack_o,
  input logic            irq_busy_o
);
  p_one_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({push_req_o, jump_req_o, irq_ack_o}));

  p_ack_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> !irq_ack_o);

  p_ack_after_jump_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_ack_o) |-> $past(jump_req_o && jump_done_i));

  p_jump_after_push_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jump_req_o) |-> $past(push_req_o && push_done_i));

  p_push_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req_o && !push_done_i) |=> (push_req_o && $stable(push_data_o)));

  p_jump_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_req_o && !jump_done_i) |=> jump_req_o);

  p_accept_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(push_req_o) |-> $past(!imm_cont_i && insn_bound_i));

  p_ret_pc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(push_req_o) |-> (push_data_o == $past(pc_i)));

  p_busy_cover_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req_o || jump_req_o || irq_ack_o) |-> irq_busy_o);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.PC_W(PC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .imm_cont_i   (imm_cont_i),
  .insn_bound_i (insn_bound_i),
  .pc_i         (pc_i),
  .push_req_o   (push_req_o),
  .push_data_o  (push_data_o),
  .push_done_i  (push_done_i),
  .jump_req_o   (jump_req_o),
  .jump_done_i  (jump_done_i),
  .irq_ack_o    (irq_ack_o),
  .irq_busy_o   (irq_busy_o)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam int unsigned PC_W = 32;
  localparam logic [PC_W-1:0] VEC = 32'h20;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            irq_req_i = 1'b0;
  logic            imm_cont_i = 1'b0;
  logic            insn_bound_i = 1'b0;
  logic [PC_W-1:0] pc_i = '0;
  logic            push_done_i = 1'b0;
  logic            jump_done_i = 1'b0;
  logic            push_req_o, jump_req_o, irq_ack_o, irq_busy_o;
  logic [PC_W-1:0] push_data_o, jump_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_entry_seq #(.PC_W(PC_W), .VEC_ADDR(VEC)) dut (.*);

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(string req, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_outs(string req);
    check(req, {31'd0, push_req_o}, 0);
    check(req, {31'd0, jump_req_o}, 0);
    check(req, {31'd0, irq_ack_o}, 0);
    check(req, {31'd0, irq_busy_o}, 0);
  endtask

  // drives handshake with given delays once push_req_o is high
  task automatic finish_entry(logic [PC_W-1:0] exp_pc, int push_wait, int jump_wait);
    check("R3", {31'd0, push_req_o}, 1);
    check("R3", push_data_o, exp_pc);
    check("R10", {31'd0, irq_busy_o}, 1);
    for (int i = 0; i < push_wait; i++) begin
      step();
      check("R6", {31'd0, push_req_o}, 1);
      check("R6", push_data_o, exp_pc);
      check("R6", {31'd0, jump_req_o}, 0);
    end
    push_done_i = 1'b1;
    step();
    push_done_i = 1'b0;
    check("R6", {31'd0, push_req_o}, 0);
    check("R6", {31'd0, jump_req_o}, 1);
    check("R4", jump_addr_o, VEC);
    for (int i = 0; i < jump_wait; i++) begin
      step();
      check("R6", {31'd0, jump_req_o}, 1);
      check("R5", {31'd0, irq_ack_o}, 0);
    end
    jump_done_i = 1'b1;
    step();
    jump_done_i = 1'b0;
    check("R5", {31'd0, irq_ack_o}, 1);
    check("R10", {31'd0, irq_busy_o}, 1);
    check("R5", {31'd0, jump_req_o}, 0);
    step();
    check("R5", {31'd0, irq_ack_o}, 0);
    check("R10", {31'd0, irq_busy_o}, 0);
  endtask

  task automatic t_reset();
    idle_outs("R11");
    check("R11", push_data_o, 0);
  endtask

  task automatic t_basic();
    insn_bound_i = 1'b1;
    pc_i = 32'hDEAD_BEE4;
    irq_req_i = 1'b1;
    step();
    check("R1", {31'd0, push_req_o}, 0);
    step();
    pc_i = 32'h1234_5678;
    finish_entry(32'hDEAD_BEE4, 0, 0);
  endtask

  task automatic t_held();
    // line still high from t_basic
    for (int i = 0; i < 6; i++) step();
    check("R2", {31'd0, push_req_o}, 0);
    check("R1", {31'd0, irq_busy_o}, 0);
    irq_req_i = 1'b0;
    step();
    step();
    check("R2", {31'd0, irq_busy_o}, 0);
  endtask

  task automatic t_imm();
    imm_cont_i = 1'b1;
    insn_bound_i = 1'b1;
    pc_i = 32'h0000_0100;
    irq_req_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      check("R7", {31'd0, push_req_o}, 0);
    end
    imm_cont_i = 1'b0;
    pc_i = 32'h0000_0104;
    step();
    finish_entry(32'h0000_0104, 2, 1);
    irq_req_i = 1'b0;
    step();
  endtask

  task automatic t_bound();
    insn_bound_i = 1'b0;
    pc_i = 32'h8000_0010;
    irq_req_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R8", {31'd0, push_req_o}, 0);
    end
    insn_bound_i = 1'b1;
    step();
    insn_bound_i = 1'b0;
    finish_entry(32'h8000_0010, 3, 3);
    irq_req_i = 1'b0;
    step();
  endtask

  task automatic t_drop();
    insn_bound_i = 1'b0;
    pc_i = 32'hFFFF_FFFC;
    irq_req_i = 1'b1;
    step();
    irq_req_i = 1'b0;
    step();
    step();
    check("R9", {31'd0, push_req_o}, 0);
    insn_bound_i = 1'b1;
    step();
    insn_bound_i = 1'b0;
    finish_entry(32'hFFFF_FFFC, 1, 0);
  endtask

  task automatic t_reset_mid();
    insn_bound_i = 1'b1;
    pc_i = 32'h0000_0040;
    irq_req_i = 1'b1;
    step();
    step();
    check("R11", {31'd0, push_req_o}, 1);
    rst_ni = 1'b0;
    #1;
    idle_outs("R11");
    step();
    rst_ni = 1'b1;
    pc_i = 32'h0000_0044;
    step();
    check("R11", {31'd0, push_req_o}, 0);
    step();
    finish_entry(32'h0000_0044, 0, 0);
    irq_req_i = 1'b0;
    insn_bound_i = 1'b0;
    step();
  endtask

  initial begin
    #1;
    t_reset();
    step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_basic();
    t_held();
    t_imm();
    t_bound();
    t_drop();
    t_reset_mid();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule